// File: doc/BRIEF.md
# Programmable Phase/Frequency Detector Controller

This block is the digital front end of a frequency synthesizer loop. It receives a divided RF (feedback) signal and a raw reference signal, divides the reference by a programmable ratio, and compares the two with a tri-state phase/frequency detector. The detector issues pump-up and pump-down commands for an external charge pump. Both divided signals are also brought out on monitor outputs, for observation or for driving a detector outside the block.

A single configuration word sets the reference ratio, a sense bit and a two-bit mode. The sense bit reverses the loop's correction direction by exchanging the detector inputs. It exchanges the monitor outputs in the same way, so an external detector sees the reversed sense too. The mode selects the following: detector on with monitors quiet, detector and monitors on, detector on only until lock with the monitors on (hand-off to an external detector), or detector permanently off. A filtered lock detector reports lock only after a run of consecutive narrow-pulse reference periods.

All inputs are synchronous to `clk`. Edges are found by comparing each sample with the one before it.

Top module: `phase_det_ctrl`

## Requirements
- R1: After reset, pump_up_o, pump_dn_o, mon_ref_o, mon_fbk_o and lock_o are low. The reference ratio is 1, the mode is 00 and the sense bit is 0.
- R2: With sense 0, a divided-reference edge raises pump_up_o and a feedback edge raises pump_dn_o. When both are high, both return low on the next cycle. The leading command therefore stays high for (lag in cycles + 1) cycles and the other for 1 cycle.
- R3: With sense 1, the detector inputs are exchanged: a feedback edge raises pump_up_o and a divided-reference edge raises pump_dn_o.
- R4: With sense 1, the monitor outputs are exchanged: mon_ref_o carries the feedback pulses and mon_fbk_o carries the divided-reference pulses. Each pulse lasts one cycle.
- R5: Mode 00 runs the detector and holds both monitor outputs low.
- R6: Mode 01 runs the detector and drives both monitor outputs.
- R7: Mode 10 drives the monitors and runs the detector until lock_o rises. After that, both pump commands are held low and lock_o stays high.
- R8: Mode 11 holds both pump commands low, drives both monitors and holds lock_o low.
- R9: Configuration word fields are: bit 0 selects the word, and only 0 is accepted. Bits 10:1 hold the reference ratio, bits 12:11 the mode and bit 13 the sense bit. Bits 15:14 are unused. A word with bit 0 = 1 changes nothing.
- R10: The reference divider emits one divided pulse per `ratio` rising reference edges. A ratio of 0 or 1 divides by 1.
- R11: A newly written ratio takes effect only after the divider's current count reaches its terminal value.
- R12: lock_o rises once 16 consecutive divided-reference periods have had no pump command high for more than 4 cycles. A longer pulse drops lock_o at once.
- R13: A wide pump pulse during acquisition restarts the count of clean periods, so momentary coincidences do not report lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration word write strobe |
| cfg_word_i | input | 16 | Configuration word (layout in R9) |
| ref_i | input | 1 | Reference signal before division |
| fbk_i | input | 1 | Divided RF feedback signal |
| pump_up_o | output | 1 | Pump-up command |
| pump_dn_o | output | 1 | Pump-down command |
| mon_ref_o | output | 1 | Divided-reference monitor (feedback when sense is 1) |
| mon_fbk_o | output | 1 | Feedback monitor (divided reference when sense is 1) |
| lock_o | output | 1 | Filtered lock indication |

## Verification
The hardest case to reach from the ports is the mode-10 hand-off. The detector only switches itself off after the lock filter has seen 16 clean periods in a row. The bench therefore first breaks any earlier lock with a deliberately wide pulse. It then feeds a long run of coincident reference and feedback edges, and only after that checks that a lagging feedback edge no longer produces any pump command while lock_o stays high. The restart of the count is exposed by placing one wide pulse between two short clean runs whose combined length would otherwise be enough for lock. A ratio change is written partway through a divider count, so that the old ratio visibly finishes first.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   // Detector / monitor operating modes (two-bit field of the control word)
   typedef enum logic [1:0] {
      MODE_RUN_QUIET = 2'b00,   // detector on, monitors held low
      MODE_RUN_MON   = 2'b01,   // detector on, monitors driven
      MODE_HANDOFF   = 2'b10,   // detector on until lock, monitors driven
      MODE_OFF       = 2'b11    // detector off, monitors driven
   } pd_mode_e;

   // Position of the word-select bit; only words with this bit clear apply
   localparam int SEL_POS   = 0;
   localparam int RATIO_LSB = 1;

endpackage

// File: rtl/pdc_ref_div.sv
module pdc_ref_div #(
   parameter int RATIO_W   = 10,
   parameter int DEF_RATIO = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               tick_o
);

   localparam logic [RATIO_W-1:0] DEF_R = RATIO_W'(DEF_RATIO);

   function automatic logic [RATIO_W-1:0] last_index(input logic [RATIO_W-1:0] r);
      return (r <= RATIO_W'(1)) ? '0 : r - RATIO_W'(1);
   endfunction

   logic               ref_q;
   logic               ref_rise;
   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] last_q;
   logic               tick_q;

   assign ref_rise = ref_i & ~ref_q;
   assign tick_o   = tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q  <= 1'b0;
         cnt_q  <= '0;
         last_q <= last_index(DEF_R);
         tick_q <= 1'b0;
      end else begin
         ref_q  <= ref_i;
         tick_q <= 1'b0;
         if (ref_rise) begin
            if (cnt_q >= last_q) begin
               cnt_q  <= '0;
               tick_q <= 1'b1;
               last_q <= last_index(ratio_i);   // new ratio loads at terminal count
            end else begin
               cnt_q <= cnt_q + RATIO_W'(1);
            end
         end
      end
   end

   // R10
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);

endmodule

// File: rtl/pdc_pfd.sv
module pdc_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic sense_i,
   input  logic ref_tick_i,
   input  logic fbk_tick_i,
   output logic up_o,
   output logic dn_o
);

   logic lead_evt;
   logic lag_evt;
   logic up_q;
   logic dn_q;

   // sense bit exchanges the two detector inputs
   assign lead_evt = sense_i ? fbk_tick_i : ref_tick_i;
   assign lag_evt  = sense_i ? ref_tick_i : fbk_tick_i;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (up_q && dn_q) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_q | lead_evt;
         dn_q <= dn_q | lag_evt;
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;

   // R2
   both_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && dn_q) |=> (!up_q && !dn_q));

   // R7
   held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!up_q && !dn_q));

endmodule

// File: rtl/pdc_lock.sv
module pdc_lock #(
   parameter int LOCK_PERIODS = 16,
   parameter int WIN_MAX      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic period_i,
   input  logic up_i,
   input  logic dn_i,
   output logic lock_o
);

   localparam int W_W = $clog2(WIN_MAX + 1);
   localparam int G_W = (LOCK_PERIODS > 2) ? $clog2(LOCK_PERIODS) : 1;
   localparam logic [W_W-1:0] W_LIM  = W_W'(WIN_MAX);
   localparam logic [G_W-1:0] G_LAST = G_W'(LOCK_PERIODS - 1);

   logic           active;
   logic           viol;
   logic [W_W-1:0] width_q;
   logic [G_W-1:0] good_q;
   logic           bad_q;
   logic           locked_q;

   assign active = up_i | dn_i;
   assign viol   = active && (width_q >= W_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         width_q  <= '0;
         good_q   <= '0;
         bad_q    <= 1'b0;
         locked_q <= 1'b0;
      end else begin
         if (!active)
            width_q <= '0;
         else if (width_q != W_LIM)
            width_q <= width_q + W_W'(1);

         if (viol) begin
            locked_q <= 1'b0;
            good_q   <= '0;
            bad_q    <= 1'b1;
         end else if (period_i) begin
            if (bad_q) begin
               bad_q <= 1'b0;                 // period that held the wide pulse ends
            end else if (good_q == G_LAST) begin
               locked_q <= 1'b1;
            end else begin
               good_q <= good_q + G_W'(1);
            end
         end
      end
   end

   assign lock_o = locked_q;

   // R12
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> !locked_q);

   // R12
   lock_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(period_i));

   // R8
   lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !locked_q);

endmodule

// File: rtl/phase_det_ctrl.sv
module phase_det_ctrl
   import pdc_pkg::*;
#(
   parameter int CFG_W        = 16,
   parameter int RATIO_W      = 10,
   parameter int DEF_RATIO    = 1,
   parameter int LOCK_PERIODS = 16,
   parameter int WIN_MAX      = 4,
   parameter bit MON_REG      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_i,
   input  logic [CFG_W-1:0] cfg_word_i,
   input  logic             ref_i,
   input  logic             fbk_i,
   output logic             pump_up_o,
   output logic             pump_dn_o,
   output logic             mon_ref_o,
   output logic             mon_fbk_o,
   output logic             lock_o
);

   localparam int MODE_LSB  = RATIO_LSB + RATIO_W;
   localparam int SENSE_POS = MODE_LSB + 2;

   // elaboration-time parameter checks
   if (CFG_W < SENSE_POS + 1) begin : g_cfg_w_bad
      $error("CFG_W too narrow for ratio, mode and sense fields");
   end
   if (RATIO_W < 1 || DEF_RATIO < 0 || DEF_RATIO >= (1 << RATIO_W)) begin : g_ratio_bad
      $error("DEF_RATIO does not fit RATIO_W");
   end
   if (LOCK_PERIODS < 2) begin : g_lock_bad
      $error("LOCK_PERIODS must be at least 2");
   end
   if (WIN_MAX < 1) begin : g_win_bad
      $error("WIN_MAX must be at least 1");
   end

   logic               sense_q;
   pd_mode_e           mode_q;
   logic [RATIO_W-1:0] ratio_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sense_q <= 1'b0;
         mode_q  <= MODE_RUN_QUIET;
         ratio_q <= RATIO_W'(DEF_RATIO);
      end else if (cfg_wr_i && !cfg_word_i[SEL_POS]) begin
         ratio_q <= cfg_word_i[MODE_LSB-1:RATIO_LSB];
         mode_q  <= pd_mode_e'(cfg_word_i[SENSE_POS-1:MODE_LSB]);
         sense_q <= cfg_word_i[SENSE_POS];
      end
   end

   // reference division
   logic ref_tick;

   pdc_ref_div #(
      .RATIO_W   (RATIO_W),
      .DEF_RATIO (DEF_RATIO)
   ) ref_div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_i   (ref_i),
      .ratio_i (ratio_q),
      .tick_o  (ref_tick)
   );

   // feedback edge, registered to match the divider's latency
   logic fbk_q;
   logic fbk_tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fbk_q      <= 1'b0;
         fbk_tick_q <= 1'b0;
      end else begin
         fbk_q      <= fbk_i;
         fbk_tick_q <= fbk_i & ~fbk_q;
      end
   end

   // mode decode
   logic lock_w;
   logic det_en;
   logic lock_en;
   logic mon_on;

   always_comb begin
      unique case (mode_q)
         MODE_RUN_QUIET: begin det_en = 1'b1;    mon_on = 1'b0; end
         MODE_RUN_MON:   begin det_en = 1'b1;    mon_on = 1'b1; end
         MODE_HANDOFF:   begin det_en = !lock_w; mon_on = 1'b1; end
         default:        begin det_en = 1'b0;    mon_on = 1'b1; end
      endcase
   end

   assign lock_en = (mode_q != MODE_OFF);

   logic up_w;
   logic dn_w;

   pdc_pfd pfd_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (det_en),
      .sense_i    (sense_q),
      .ref_tick_i (ref_tick),
      .fbk_tick_i (fbk_tick_q),
      .up_o       (up_w),
      .dn_o       (dn_w)
   );

   pdc_lock #(
      .LOCK_PERIODS (LOCK_PERIODS),
      .WIN_MAX      (WIN_MAX)
   ) lock_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (lock_en),
      .period_i (ref_tick),
      .up_i     (up_w),
      .dn_i     (dn_w),
      .lock_o   (lock_w)
   );

   // monitor outputs: exchanged by the sense bit, gated by the mode
   logic sel_ref;
   logic sel_fbk;

   assign sel_ref = mon_on & (sense_q ? fbk_tick_q : ref_tick);
   assign sel_fbk = mon_on & (sense_q ? ref_tick : fbk_tick_q);

   if (MON_REG) begin : g_mon_reg
      logic mon_ref_q;
      logic mon_fbk_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mon_ref_q <= 1'b0;
            mon_fbk_q <= 1'b0;
         end else begin
            mon_ref_q <= sel_ref;
            mon_fbk_q <= sel_fbk;
         end
      end
      assign mon_ref_o = mon_ref_q;
      assign mon_fbk_o = mon_fbk_q;
   end else begin : g_mon_comb
      assign mon_ref_o = sel_ref;
      assign mon_fbk_o = sel_fbk;
   end

   assign pump_up_o = up_w;
   assign pump_dn_o = dn_w;
   assign lock_o    = lock_w;

   // R7
   handoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HANDOFF && lock_w && $past(mode_q == MODE_HANDOFF && lock_w))
         |-> (!pump_up_o && !pump_dn_o));

endmodule

// File: tb/phase_det_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_det_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_word = '0;
   logic        ref_in = 1'b0;
   logic        fbk_in = 1'b0;
   logic        up, dn, mref, mfbk, lock;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   phase_det_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr_i   (cfg_wr),
      .cfg_word_i (cfg_word),
      .ref_i      (ref_in),
      .fbk_i      (fbk_in),
      .pump_up_o  (up),
      .pump_dn_o  (dn),
      .mon_ref_o  (mref),
      .mon_fbk_o  (mfbk),
      .lock_o     (lock)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // word layout (R9): bit0 select, 10:1 ratio, 12:11 mode, 13 sense
   function automatic logic [15:0] mk(input bit s, input bit [1:0] md, input int r, input bit sel);
      return 16'({s, md, 10'(r), sel});
   endfunction

   task automatic cfg_write(input logic [15:0] w);
      @(negedge clk);
      cfg_wr   = 1'b1;
      cfg_word = w;
      @(negedge clk);
      cfg_wr   = 1'b0;
      cfg_word = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      ref_in = 1'b0;
      fbk_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // results of one reference/feedback edge pair
   int up_cnt, dn_cnt, mr_cnt, mf_cnt, mr_first, mf_first;

   localparam int T_REF = 10;

   task automatic pulse_pair(input int d);
      up_cnt = 0; dn_cnt = 0; mr_cnt = 0; mf_cnt = 0;
      mr_first = -1; mf_first = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (up)   up_cnt++;
         if (dn)   dn_cnt++;
         if (mref) begin mr_cnt++; if (mr_first < 0) mr_first = i; end
         if (mfbk) begin mf_cnt++; if (mf_first < 0) mf_first = i; end
         ref_in = (i >= T_REF)     && (i < T_REF + 3);
         fbk_in = (i >= T_REF + d) && (i < T_REF + d + 3);
      end
      ref_in = 1'b0;
      fbk_in = 1'b0;
   endtask

   int edge_cnt;
   task automatic ref_edges(input int n);
      edge_cnt = 0;
      for (int e = 0; e < n * 4 + 4; e++) begin
         @(negedge clk);
         if (mref) edge_cnt++;
         ref_in = (e < n * 4) && ((e % 4) < 2);
      end
      ref_in = 1'b0;
   endtask

   typedef struct packed {
      logic              sense;
      logic [1:0]        mode;
      logic signed [4:0] d;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 2'b01,  5'sd3},
      '{1'b0, 2'b01, -5'sd2},
      '{1'b1, 2'b01,  5'sd3},
      '{1'b1, 2'b01, -5'sd2},
      '{1'b0, 2'b00,  5'sd2},
      '{1'b1, 2'b00,  5'sd0},
      '{1'b0, 2'b10,  5'sd1},
      '{1'b0, 2'b11,  5'sd3},
      '{1'b1, 2'b11, -5'sd1}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "outputs after reset", int'({up, dn, mref, mfbk, lock}), 0);

      // R1 / R5: defaults are mode 00, sense 0, ratio 1
      pulse_pair(2);
      chk("R1", "default up width", up_cnt, 3);
      chk("R5", "default dn width", dn_cnt, 1);
      chk("R5", "default monitors quiet", mr_cnt + mf_cnt, 0);

      // vector table: R2 R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         int dd, ta, tb, eu, ed, emon;
         bit en;
         dd = VECS[v].d;
         cfg_write(mk(VECS[v].sense, VECS[v].mode, 1, 1'b0));
         pulse_pair(dd);
         ta = VECS[v].sense ? T_REF + dd : T_REF;
         tb = VECS[v].sense ? T_REF : T_REF + dd;
         en = (VECS[v].mode != 2'b11);
         if (!en)          begin eu = 0;           ed = 0;           end
         else if (ta < tb) begin eu = tb - ta + 1; ed = 1;           end
         else if (tb < ta) begin eu = 1;           ed = ta - tb + 1; end
         else              begin eu = 1;           ed = 1;           end
         emon = (VECS[v].mode != 2'b00) ? 1 : 0;
         chk("R2/R3/R8", $sformatf("vec %0d up width", v), up_cnt, eu);
         chk("R2/R3/R8", $sformatf("vec %0d dn width", v), dn_cnt, ed);
         chk("R5/R6", $sformatf("vec %0d monitor pulses", v), mr_cnt * 10 + mf_cnt, emon * 11);
         if (emon != 0)
            chk("R4", $sformatf("vec %0d monitor spacing", v), mr_first - mf_first, ta - tb);
      end

      // R10 / R11: ratio handling
      do_reset();
      cfg_write(mk(0, 2'b01, 3, 1'b0));
      ref_edges(1);
      chk("R11", "old ratio 1 finishes first", edge_cnt, 1);
      ref_edges(6);
      chk("R10", "ratio 3 over 6 edges", edge_cnt, 2);
      ref_edges(1);
      chk("R10", "ratio 3 mid-count", edge_cnt, 0);
      cfg_write(mk(0, 2'b01, 2, 1'b0));
      ref_edges(2);
      chk("R11", "old ratio 3 completes", edge_cnt, 1);
      ref_edges(4);
      chk("R10", "ratio 2 over 4 edges", edge_cnt, 2);
      cfg_write(mk(0, 2'b01, 0, 1'b0));
      ref_edges(2);
      chk("R11", "ratio 2 completes before 0 applies", edge_cnt, 1);
      ref_edges(3);
      chk("R10", "ratio 0 divides by 1", edge_cnt, 3);

      // R9: word with select bit set is ignored
      do_reset();
      cfg_write(mk(0, 2'b01, 1, 1'b0));
      cfg_write(mk(1, 2'b00, 5, 1'b1));
      pulse_pair(2);
      chk("R9", "ignored word: up width", up_cnt, 3);
      chk("R9", "ignored word: monitors", mr_cnt * 10 + mf_cnt, 11);
      chk("R9", "ignored word: spacing", mr_first - mf_first, -2);

      // R12 / R13: lock filter
      repeat (10) pulse_pair(0);
      chk("R12", "no lock after 10 clean periods", lock, 0);
      pulse_pair(6);
      repeat (10) pulse_pair(0);
      chk("R13", "wide pulse restarts count", lock, 0);
      repeat (8) pulse_pair(0);
      chk("R12", "lock after 16 clean periods", lock, 1);
      pulse_pair(6);
      chk("R12", "wide pulse drops lock", lock, 0);

      // R7: hand-off mode
      cfg_write(mk(0, 2'b10, 1, 1'b0));
      repeat (18) pulse_pair(0);
      chk("R7", "hand-off reaches lock", lock, 1);
      pulse_pair(3);
      chk("R7", "detector off after lock", up_cnt + dn_cnt, 0);
      chk("R7", "lock held after hand-off", lock, 1);
      chk("R7", "monitors on in hand-off", mr_cnt * 10 + mf_cnt, 11);

      // R8: detector off
      cfg_write(mk(0, 2'b11, 1, 1'b0));
      pulse_pair(0);
      chk("R8", "pumps low in mode 11", up_cnt + dn_cnt, 0);
      chk("R8", "lock low in mode 11", lock, 0);
      chk("R8", "monitors on in mode 11", mr_cnt * 10 + mf_cnt, 11);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule